// File: doc/BRIEF.md
# Checkpointed Global History with Folded Histories

This block holds the speculative branch history of a predictor front end. Two circular bit buffers, one for taken/not-taken outcomes and one for path bits, are each addressed by a write pointer. Every accepted update writes one bit into each buffer and advances both pointers. Alongside the buffers, the block keeps a configurable set of folded histories. Each fold compresses the most recent L outcome bits into W bits, and the table index and tag hashes downstream consume these folds. The default set has 27 folds. Twelve serve the four tagged direction tables, as index, tag-1 and tag-2 folds over 8, 13, 32 and 119 bits. Twelve serve the indirect-target tables. Three serve the statistical corrector, over 4, 16 and 64 bits.

The checkpoint the block exports is only the pair of pointers, which the fetch queue stores per slot. On a misprediction the recovery logic returns that checkpoint. The block restores the pointers at once. It then rebuilds every fold from the buffer contents, one history position per cycle, while `busy` is high. Updates offered while `busy` is high are dropped, so the producer holds them until `busy` falls.

Top module: `ghist_ckpt`

## Requirements
- R1: After reset, `ckpt`, `busy`, `phist` and every fold read zero.
- R2: `ckpt` is {global pointer, path pointer}, with the global pointer in the upper bits. By default this is 8 + 5 = 13 bits. Each accepted update advances both pointers by one, modulo their buffer lengths.
- R3: `phist` bit i holds the path bit of the i-th most recent accepted update, with bit 0 the newest. This holds for every age that discarded wrong-path updates have not overwritten.
- R4: Fold k, in lane k of `folds` (bits k*LANE_W upward, zero-extended), equals the XOR over ages i < FOLD_LEN[k] of the taken bit of age i, placed at bit position (i mod FOLD_WID[k]). The fold reflects an update on the cycle after that update is accepted.
- R5: A rollback loads `rbk_ckpt` into `ckpt` on the next cycle and raises `busy`. `busy` then stays high for exactly MAX_LEN cycles, where MAX_LEN is the longest fold length.
- R6: When `busy` falls after a rollback, every fold equals the R4 definition over the history ending at the restored pointer.
- R7: An update presented while `busy` is high is dropped. The pointers, `phist` and the final folds do not change because of it.
- R8: A rollback that arrives while `busy` is high restarts the rebuild from the new checkpoint. `busy` then stays high for a further MAX_LEN cycles.
- R9: When a rollback and an update arrive in the same cycle, the rollback takes effect and the update is dropped.
- R10: With no update and no rollback, and `busy` low, `ckpt`, `phist` and `folds` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| upd_valid | input | 1 | Speculative history update request |
| upd_taken | input | 1 | Outcome bit to append to the global history |
| upd_path | input | 1 | Path bit to append to the path history |
| rbk_valid | input | 1 | Rollback request |
| rbk_ckpt | input | $clog2(GH_LEN)+$clog2(PH_LEN) | Checkpoint to restore |
| ckpt | output | $clog2(GH_LEN)+$clog2(PH_LEN) | Current pointer pair, for storage in a fetch queue slot |
| busy | output | 1 | Fold rebuild in progress; updates are dropped |
| phist | output | PH_LEN | Path history, newest bit at bit 0 |
| folds | output | NUM_FOLDS*LANE_W | All folded histories, one zero-extended lane each |

## Verification
The assertions assume that every rollback carries a checkpoint taken earlier on the current path. They also assume that no more than GH_LEN minus the longest fold length updates were accepted after that checkpoint, so that the rebuild never reads bits that wrong-path updates overwrote. The assertions further assume that producers treat `busy` as a stall. The stimulus enforces these limits with a bench of a 32-bit global buffer, a 16-bit path buffer and a longest fold of 24 bits. Each wrong path is capped at eight updates and is followed by enough correct updates to flush the stale region before the next one. Path-history ages that a discarded path may have overwritten are masked out of the comparison.

// File: rtl/ghist_ckpt.sv
module ghist_ckpt #(
  parameter int GH_LEN    = 256,
  parameter int PH_LEN    = 32,
  parameter int NUM_FOLDS = 27,
  parameter int LANE_W    = 12,
  parameter int FOLD_LEN [NUM_FOLDS] = '{
    8, 8, 8, 13, 13, 13, 32, 32, 32, 119, 119, 119,
    8, 8, 8, 13, 13, 13, 16, 16, 16, 32, 32, 32,
    4, 16, 64},
  parameter int FOLD_WID [NUM_FOLDS] = '{
    10, 8, 7, 10, 8, 7, 10, 8, 7, 10, 8, 7,
    8, 8, 8, 9, 9, 8, 9, 9, 8, 9, 9, 9,
    9, 9, 9}
) (
  input  logic clk,
  input  logic rst_n,
  input  logic upd_valid,
  input  logic upd_taken,
  input  logic upd_path,
  input  logic rbk_valid,
  input  logic [$clog2(GH_LEN)+$clog2(PH_LEN)-1:0] rbk_ckpt,
  output logic [$clog2(GH_LEN)+$clog2(PH_LEN)-1:0] ckpt,
  output logic busy,
  output logic [PH_LEN-1:0] phist,
  output logic [NUM_FOLDS*LANE_W-1:0] folds
);

  function automatic int longest();
    int m = 2;
    for (int k = 0; k < NUM_FOLDS; k++)
      if (FOLD_LEN[k] > m) m = FOLD_LEN[k];
    return m;
  endfunction

  localparam int GP_W    = $clog2(GH_LEN);
  localparam int PP_W    = $clog2(PH_LEN);
  localparam int CK_W    = GP_W + PP_W;
  localparam int MAX_LEN = longest();
  localparam int AGE_W   = $clog2(MAX_LEN);

  logic [GH_LEN-1:0] gbuf;
  logic [PH_LEN-1:0] pbuf;
  logic [GP_W-1:0]   gptr;
  logic [PP_W-1:0]   pptr;
  logic [AGE_W-1:0]  age;
  logic [GP_W-1:0]   rb_idx;
  logic              rb_bit;
  logic              accept;

  assign accept = upd_valid && !busy && !rbk_valid;
  assign ckpt   = {gptr, pptr};
  assign rb_idx = gptr - GP_W'(1) - GP_W'(age);
  assign rb_bit = gbuf[rb_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gbuf <= '0;
      pbuf <= '0;
      gptr <= '0;
      pptr <= '0;
      busy <= 1'b0;
      age  <= '0;
    end else if (rbk_valid) begin
      gptr <= rbk_ckpt[CK_W-1:PP_W];
      pptr <= rbk_ckpt[PP_W-1:0];
      busy <= 1'b1;
      age  <= AGE_W'(MAX_LEN - 1);
    end else if (busy) begin
      age <= age - 1'b1;
      if (age == '0) busy <= 1'b0;
    end else if (upd_valid) begin
      gbuf[gptr] <= upd_taken;
      pbuf[pptr] <= upd_path;
      gptr <= gptr + 1'b1;
      pptr <= pptr + 1'b1;
    end
  end

  always_comb
    for (int i = 0; i < PH_LEN; i++)
      phist[i] = pbuf[pptr - PP_W'(i + 1)];

  for (genvar k = 0; k < NUM_FOLDS; k++) begin : g_fold
    localparam int L  = FOLD_LEN[k];
    localparam int W  = FOLD_WID[k];
    localparam int SH = L % W;
    logic [W-1:0]    f;
    logic [W-1:0]    rot;
    logic [GP_W-1:0] old_idx;

    assign rot     = (f << 1) | (f >> (W - 1));
    assign old_idx = gptr - GP_W'(L);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         f <= '0;
      else if (rbk_valid) f <= '0;
      else if (busy)      f <= rot ^ W'(rb_bit && (int'(age) < L));
      else if (accept)    f <= rot ^ W'(upd_taken) ^ (W'(gbuf[old_idx]) << SH);
    end

    assign folds[k*LANE_W +: LANE_W] = LANE_W'(f);
  end

endmodule

// File: rtl/ghist_ckpt_chk.sv
module ghist_ckpt_chk #(
  parameter int CK_W    = 13,
  parameter int PP_W    = 5,
  parameter int PH      = 32,
  parameter int FB      = 324,
  parameter int MAX_LEN = 119
) (
  input logic clk,
  input logic rst_n,
  input logic upd_valid,
  input logic rbk_valid,
  input logic [CK_W-1:0] rbk_ckpt,
  input logic [CK_W-1:0] ckpt,
  input logic busy,
  input logic [PH-1:0] phist,
  input logic [FB-1:0] folds
);

  int brun;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         brun <= 0;
    else if (rbk_valid) brun <= 0;
    else if (busy)      brun <= brun + 1;
  end

  assert_rbk_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rbk_valid |=> (ckpt == $past(rbk_ckpt)) && busy);

  assert_rbk_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rbk_valid && upd_valid) |=> ckpt == $past(rbk_ckpt));

  assert_advance_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && !busy && !rbk_valid) |=>
      (ckpt[CK_W-1:PP_W] == $past(ckpt[CK_W-1:PP_W]) + 1'b1) &&
      (ckpt[PP_W-1:0] == $past(ckpt[PP_W-1:0]) + 1'b1));

  assert_drop_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !rbk_valid) |=> $stable(ckpt) && $stable(phist));

  assert_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !upd_valid && !rbk_valid) |=>
      $stable(ckpt) && $stable(phist) && $stable(folds));

  assert_rebuild_len_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> brun == MAX_LEN);

endmodule

bind ghist_ckpt ghist_ckpt_chk #(
  .CK_W(CK_W), .PP_W(PP_W), .PH(PH_LEN), .FB(NUM_FOLDS*LANE_W), .MAX_LEN(MAX_LEN)
) u_chk (
  .clk(clk), .rst_n(rst_n), .upd_valid(upd_valid), .rbk_valid(rbk_valid),
  .rbk_ckpt(rbk_ckpt), .ckpt(ckpt), .busy(busy), .phist(phist), .folds(folds)
);

// File: tb/tb_ghist_ckpt.sv
`timescale 1ns/1ps
module tb_ghist_ckpt;
  localparam int GH = 32;
  localparam int PH = 16;
  localparam int NF = 5;
  localparam int LANE = 8;
  localparam int CK_W = 9;
  localparam int MAXL = 24;
  localparam int LEN [NF] = '{3, 7, 12, 16, 24};
  localparam int WID [NF] = '{5, 3, 4, 6, 7};

  logic clk = 0, rst_n = 0;
  logic upd_valid = 0, upd_taken = 0, upd_path = 0, rbk_valid = 0;
  logic [CK_W-1:0] rbk_ckpt = '0, ckpt;
  logic busy;
  logic [PH-1:0] phist;
  logic [NF*LANE-1:0] folds;

  ghist_ckpt #(.GH_LEN(GH), .PH_LEN(PH), .NUM_FOLDS(NF), .LANE_W(LANE),
               .FOLD_LEN(LEN), .FOLD_WID(WID)) dut (
    .clk(clk), .rst_n(rst_n), .upd_valid(upd_valid), .upd_taken(upd_taken),
    .upd_path(upd_path), .rbk_valid(rbk_valid), .rbk_ckpt(rbk_ckpt),
    .ckpt(ckpt), .busy(busy), .phist(phist), .folds(folds));

  always #10 clk = ~clk;

  int nchk = 0, nfail = 0;
  bit done = 0;
  bit tl [8192];
  bit pl [8192];
  int cnt = 0, lead = 0;
  logic [15:0] lfsr = 16'hACE1;

  task automatic chk(bit ok, string r, longint act, longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  function automatic bit tk(int a);
    return (cnt - 1 - a < 0) ? 1'b0 : tl[cnt - 1 - a];
  endfunction

  function automatic int exp_fold(int k);
    int r = 0;
    for (int i = 0; i < LEN[k]; i++)
      if (tk(i)) r ^= (1 << (i % WID[k]));
    return r;
  endfunction

  function automatic int ck_of(int c);
    return (c % GH) * PH + (c % PH);
  endfunction

  task automatic check_all(string fr, string cr);
    int e, m, pe, pm;
    e = ck_of(cnt);
    chk(ckpt == CK_W'(e), cr, ckpt, e);
    chk(busy == 1'b0, cr, busy, 0);
    for (int k = 0; k < NF; k++) begin
      e = exp_fold(k);
      chk(folds[k*LANE +: LANE] == LANE'(e), fr, folds[k*LANE +: LANE], e);
    end
    m = PH - lead; pe = 0; pm = 0;
    for (int i = 0; i < m; i++) begin
      pm |= (1 << i);
      if (cnt - 1 - i >= 0 && pl[cnt - 1 - i]) pe |= (1 << i);
    end
    chk((int'(phist) & pm) == pe, "R3", int'(phist) & pm, pe);
  endtask

  task automatic step_lfsr();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  endtask

  task automatic upd(bit chkit);
    step_lfsr();
    upd_valid = 1; upd_taken = lfsr[0]; upd_path = lfsr[3];
    @(negedge clk);
    upd_valid = 0;
    tl[cnt] = lfsr[0]; pl[cnt] = lfsr[3];
    cnt++;
    if (lead > 0) lead--;
    if (chkit) check_all("R4", "R2");
  endtask

  initial begin
    #3000000;
    if (!done) begin
      done = 1;
      nfail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(ckpt == '0, "R1", ckpt, 0);
    chk(busy == 1'b0, "R1", busy, 0);
    chk(folds == '0, "R1", folds, 0);
    chk(phist == '0, "R1", phist, 0);

    for (int i = 0; i < 200; i++) upd(1'b1);

    for (int r = 0; r < 90; r++) begin
      int c, n, bc, expb;
      bit inj, rs, same;
      for (int i = 0; i < 10; i++) upd(1'b1);
      c = cnt;
      n = r % 9;
      inj  = (r % 3 == 1);
      rs   = (r % 5 == 2);
      same = (r % 7 == 3);
      for (int i = 0; i < n; i++) upd(1'b0);
      rbk_valid = 1; rbk_ckpt = CK_W'(ck_of(c));
      if (same) begin upd_valid = 1; upd_taken = 1; upd_path = 1; end
      @(negedge clk);
      rbk_valid = 0; upd_valid = 0;
      lead = cnt + lead - c;
      cnt = c;
      chk(ckpt == CK_W'(ck_of(c)), same ? "R9" : "R5", ckpt, ck_of(c));
      chk(busy == 1'b1, "R5", busy, 1);
      bc = 0;
      while (busy && bc < 1000) begin
        bc++;
        upd_valid = (inj && bc == 5);
        upd_taken = 1; upd_path = 1;
        rbk_valid = (rs && bc == 10);
        @(negedge clk);
        if (inj && bc == 5)
          chk(ckpt == CK_W'(ck_of(c)), "R7", ckpt, ck_of(c));
      end
      upd_valid = 0; rbk_valid = 0;
      expb = rs ? 10 + MAXL : MAXL;
      chk(bc == expb, rs ? "R8" : "R5", bc, expb);
      check_all("R6", inj ? "R7" : "R5");
    end

    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      check_all("R10", "R10");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule